// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block is the host side of a three-wire serial configuration EEPROM that stores 16-bit words. It drives the chip select, shift clock and serial data toward the memory and samples the serial data coming back. A client issues read, write or erase requests through a single-cycle request strobe and receives a one-cycle acknowledge when the access is complete. Read data is returned as a 16-bit word.

After reset the block sizes the attached part without help. It reads word 0 using a 6-bit address. If the returned word matches a known signature, the part is taken to use 6 address bits; otherwise it is taken to use 8. Each write or erase is automatically preceded by a write-enable frame. It is followed by a busy poll that holds chip select high until the part signals ready, or until a poll limit is reached. A programmable divider sets the half-period of the shift clock.

Top module: `uwire_eeprom_master`

## Requirements
- R1: After reset the block reads word 0 with a 6-bit address while `busy` is high. It then sets `wide_addr` to 0 if the word equals 0x8129 and to 1 otherwise, and drops `busy`. All later frames use 6 address bits (`wide_addr`=0) or 8 address bits (`wide_addr`=1), taken from the low bits of `req_addr`.
- R2: A read request (`req_op`=0) sends opcode bits 110, then the address, then 16 further clocks. `rd_data` is the last 16 sampled bits, first sampled bit most significant. `ack` pulses for exactly one cycle, (40+2A)·H cycles after the accepting edge, where A is the address width and H is the half-period.
- R3: Bits are sent most significant first. Data out changes only while the shift clock is low. The shift clock is high only while chip select is high. Data in is sampled at the end of each high phase.
- R4: Each low and high phase of the shift clock lasts H system clocks. H equals `half_div`, except that values below 2 give H=2.
- R5: A write request (`req_op`=1) sends a write-enable frame of 3+A bits, 1_0011 followed by zeros. It then sends opcode bits 101, the address and the 16 data bits of `req_wdata`, and then performs the busy poll.
- R6: An erase request (`req_op`=2) sends the same write-enable frame, then opcode bits 111 and the address, and then performs the busy poll.
- R7: During the busy poll, chip select is high and the shift clock is low, and data in is sampled once every H cycles. The first high sample ends the poll. Chip select then drops, and `ack` follows one half-period later.
- R8: If POLL_MAX samples all read low, `err_timeout` is set. It stays set until reset, and `ack` is still returned.
- R9: Every frame ends with the shift clock low and chip select high for H cycles. Chip select is then low for at least H cycles before the next frame starts or `ack` is raised.
- R10: While `busy` is high, a request has no effect on the memory or the outputs. A request with `req_op`=3 is never accepted.
- R11: During reset, chip select, shift clock, `ack` and `err_timeout` are low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Shift-clock half-period in system clocks (minimum 2) |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 not accepted |
| req_addr | input | 8 | Word address; low 6 or 8 bits are used |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Access or sizing in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word returned by the last read |
| wide_addr | output | 1 | 1 when 8 address bits are in use |
| err_timeout | output | 1 | Sticky busy-poll timeout flag |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Shift clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data / ready from the memory |

## Verification
A read's acknowledge is due exactly (2·(19+A)+2)·H cycles after the edge that accepts the request. The bench counts falling edges from that edge and compares `ack` against this single expected cycle on every clock of the window, so an early, late or doubled pulse is caught. For writes and erases, the completion time depends on the memory model's internal busy time. The bench therefore records the cycle when the model turns ready and requires the acknowledge to land within two half-periods plus three cycles after it. The clock phase lengths, the frame endings and data-out stability are measured on every falling edge against the current half-period.

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master #(
  parameter int          DIV_W    = 8,
  parameter int          POLL_MAX = 10000,
  parameter logic [15:0] SIG_WORD = 16'h8129
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [7:0]       req_addr,
  input  logic [15:0]      req_wdata,
  output logic             busy,
  output logic             ack,
  output logic [15:0]      rd_data,
  output logic             wide_addr,
  output logic             err_timeout,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);

  localparam int FRM_W  = 27;
  localparam int CNT_W  = $clog2(FRM_W + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ER = 2'd2, OP_NONE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_BIT, S_TAIL, S_GAP, S_POLL} st_t;
  typedef enum logic [2:0] {K_SIZE, K_READ, K_EWEN, K_WRITE, K_DONE} step_t;

  st_t               st;
  step_t             step;
  logic              sized, phase;
  logic [DIV_W-1:0]  tmr;
  logic [CNT_W-1:0]  bits_left;
  logic [FRM_W-1:0]  shout;
  logic [15:0]       shin;
  logic [POLL_W-1:0] polls;
  logic [1:0]        op_q;
  logic [7:0]        addr_q;
  logic [15:0]       data_q;
  logic [FRM_W-1:0]  nxt_frame;
  logic [CNT_W-1:0]  nxt_bits;

  wire [DIV_W-1:0] hmin1  = (half_div < DIV_W'(2)) ? DIV_W'(1) : half_div - DIV_W'(1);
  wire             tdone  = (tmr == '0);
  wire             accept = (st == S_IDLE) && sized && req_valid && (req_op != OP_NONE);
  wire             launch = (st == S_IDLE) && (!sized || accept);
  wire             chain  = (st == S_GAP) && tdone && (step == K_EWEN);
  wire [CNT_W-1:0] short_n = wide_addr ? CNT_W'(11) : CNT_W'(9);
  wire [CNT_W-1:0] long_n  = wide_addr ? CNT_W'(27) : CNT_W'(25);

  function automatic logic [FRM_W-1:0] frame_of(input logic [2:0] op, input logic [7:0] a,
                                                 input logic [15:0] d, input logic w);
    return w ? {op, a, d} : {op, a[5:0], d, 2'b00};
  endfunction

  always_comb begin
    nxt_frame = '0;
    nxt_bits  = '0;
    if (st == S_IDLE) begin
      if (!sized) begin
        nxt_frame = frame_of(3'b110, 8'h00, 16'h0000, 1'b0);
        nxt_bits  = CNT_W'(25);
      end else if (req_op == OP_RD) begin
        nxt_frame = frame_of(3'b110, req_addr, 16'h0000, wide_addr);
        nxt_bits  = long_n;
      end else begin
        nxt_frame = frame_of(3'b100, wide_addr ? 8'hC0 : 8'h30, 16'h0000, wide_addr);
        nxt_bits  = short_n;
      end
    end else if (op_q == OP_WR) begin
      nxt_frame = frame_of(3'b101, addr_q, data_q, wide_addr);
      nxt_bits  = long_n;
    end else begin
      nxt_frame = frame_of(3'b111, addr_q, 16'h0000, wide_addr);
      nxt_bits  = short_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= K_SIZE; sized <= 1'b0; phase <= 1'b0;
      busy <= 1'b1; ack <= 1'b0; rd_data <= '0; wide_addr <= 1'b0; err_timeout <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
      tmr <= '0; bits_left <= '0; shout <= '0; shin <= '0; polls <= '0;
      op_q <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      ack <= 1'b0;
      if (launch || chain) begin
        shout     <= nxt_frame << 1;
        ee_di     <= nxt_frame[FRM_W-1];
        bits_left <= nxt_bits - CNT_W'(1);
        phase     <= 1'b0;
        tmr       <= hmin1;
        ee_cs     <= 1'b1;
        ee_sk     <= 1'b0;
        st        <= S_BIT;
      end
      if (launch) begin
        busy <= 1'b1;
        if (!sized) step <= K_SIZE;
        else begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_wdata;
          step   <= (req_op == OP_RD) ? K_READ : K_EWEN;
        end
      end
      if (chain) step <= K_WRITE;
      if (st != S_IDLE && !chain) begin
        if (!tdone) tmr <= tmr - DIV_W'(1);
        else begin
          tmr <= hmin1;
          case (st)
            S_BIT: begin
              if (!phase) begin
                ee_sk <= 1'b1;
                phase <= 1'b1;
              end else begin
                shin  <= {shin[14:0], ee_do};
                ee_sk <= 1'b0;
                phase <= 1'b0;
                if (bits_left == '0) begin
                  ee_di <= 1'b0;
                  st    <= S_TAIL;
                end else begin
                  ee_di     <= shout[FRM_W-1];
                  shout     <= {shout[FRM_W-2:0], 1'b0};
                  bits_left <= bits_left - CNT_W'(1);
                end
              end
            end
            S_TAIL: begin
              ee_cs <= 1'b0;
              st    <= S_GAP;
            end
            S_GAP: begin
              case (step)
                K_SIZE: begin
                  wide_addr <= (shin != SIG_WORD);
                  sized     <= 1'b1;
                  busy      <= 1'b0;
                  st        <= S_IDLE;
                end
                K_READ: begin
                  rd_data <= shin;
                  ack     <= 1'b1;
                  busy    <= 1'b0;
                  st      <= S_IDLE;
                end
                K_WRITE: begin
                  ee_cs <= 1'b1;
                  polls <= '0;
                  step  <= K_DONE;
                  st    <= S_POLL;
                end
                default: begin
                  ack  <= 1'b1;
                  busy <= 1'b0;
                  st   <= S_IDLE;
                end
              endcase
            end
            S_POLL: begin
              if (ee_do) begin
                ee_cs <= 1'b0;
                st    <= S_GAP;
              end else if (polls == POLL_W'(POLL_MAX - 1)) begin
                err_timeout <= 1'b1;
                ee_cs       <= 1'b0;
                st          <= S_GAP;
              end else begin
                polls <= polls + POLL_W'(1);
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk && $past(ee_sk) |-> $stable(ee_di)); // R3
  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R3
  AST_SK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> !$past(ee_sk, 2)); // R4
  AST_CS_FALL_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> !ee_sk && !$past(ee_sk)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R2
  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy && !ee_cs); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout); // R8

endmodule

// File: tb/tb_uwire_eeprom_master.sv
`timescale 1ns/1ps
module tb_uwire_eeprom_master;
  localparam int BUSY_CYC = 37;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd3;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        busy, ack, wide_addr, err_timeout, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  uwire_eeprom_master dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack), .rd_data(rd_data),
    .wide_addr(wide_addr), .err_timeout(err_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  // behavioural memory model
  int          m_abits = 6;
  bit          stuck = 1'b0;
  logic [15:0] mem [256];
  int          rxcnt, cur_addr, wbusy, ewen_cnt, noprot_cnt, cyc, ready_at;
  logic [31:0] rx;
  bit          rd_cmd, ewen;
  logic        do_q, p_sk, p_cs;

  function automatic logic [15:0] init_word(input int i, input int ab);
    if (i == 0) return (ab == 6) ? 16'h8129 : 16'h8139;
    return 16'((i * 257) ^ 23100);
  endfunction

  assign ee_do = (ee_cs && rxcnt == 0) ? (!stuck && (wbusy == 0)) : do_q;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_word(i, m_abits);
      rxcnt = 0; rx = 0; ewen = 0; wbusy = 0; do_q = 0; rd_cmd = 0;
      ewen_cnt = 0; noprot_cnt = 0; ready_at = 0; cur_addr = 0;
    end else begin
      if (wbusy > 0) begin
        wbusy--;
        if (wbusy == 0) ready_at = cyc;
      end
      if (ee_cs && !p_cs) begin rxcnt = 0; do_q = 0; end
      if (ee_cs && ee_sk && !p_sk) begin
        rxcnt++;
        rx = {rx[30:0], ee_di};
        if (rxcnt == 3) rd_cmd = (rx[2:0] == 3'b110);
        if (rxcnt == 3 + m_abits) cur_addr = int'(rx) & ((1 << m_abits) - 1);
        if (rd_cmd && rxcnt > 3 + m_abits && rxcnt <= 19 + m_abits)
          do_q = mem[cur_addr][19 + m_abits - rxcnt];
      end
      if (!ee_cs && p_cs) begin
        if (rxcnt == 3 + m_abits && (rx & ((32'd1 << (3 + m_abits)) - 1)) == (32'b10011 << (m_abits - 2))) begin
          ewen = 1; ewen_cnt++;
        end else if (rxcnt == 19 + m_abits && ((rx >> (16 + m_abits)) & 32'd7) == 32'd5) begin
          if (ewen) begin mem[cur_addr] = rx[15:0]; wbusy = BUSY_CYC; ewen = 0; end
          else noprot_cnt++;
        end else if (rxcnt == 3 + m_abits && ((rx >> m_abits) & 32'd7) == 32'd7) begin
          if (ewen) begin mem[cur_addr] = 16'hFFFF; wbusy = BUSY_CYC; ewen = 0; end
          else noprot_cnt++;
        end
        rxcnt = 0; do_q = 0; rd_cmd = 0;
      end
    end
    p_sk = ee_sk; p_cs = ee_cs;
  end

  // pin timing monitor
  int   cur_h = 3, run, viol_di, viol_ph, viol_end;
  logic q_sk, q_cs, q_di;
  bit   seen_fall;
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0; seen_fall = 0; q_sk = 0; q_cs = 0; q_di = 0;
    end else begin
      if (ee_sk && q_sk && ee_di != q_di) viol_di++;
      if (ee_sk != q_sk || ee_cs != q_cs) begin
        if (ee_sk != q_sk && run != cur_h) viol_ph++;
        if (!ee_cs && q_cs) begin
          if (ee_sk || q_sk || run < cur_h) viol_end++;
          seen_fall = 1;
        end
        if (ee_cs && !q_cs && seen_fall && run < cur_h) viol_end++;
        run = 1;
      end else run++;
      q_sk = ee_sk; q_cs = ee_cs; q_di = ee_di;
    end
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int ab);
    m_abits = ab;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, ee_cs, ee_sk, ack, err_timeout} == 5'b10000, "R11 reset state",
        {busy, ee_cs, ee_sk, ack, err_timeout}, 5'b10000);
    rst_n = 1'b1;
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    chk(!busy, "R1 sizing completes", busy, 0);
    chk(wide_addr == (ab == 8), "R1 address width", wide_addr, (ab == 8));
  endtask

  task automatic do_read(input logic [7:0] a, input int ab, input bit inject, input string tag);
    int due, bad;
    logic [15:0] got, exp;
    exp = mem[int'(a) & ((1 << ab) - 1)];
    got = 16'h0;
    bad = 0;
    due = (40 + 2 * ab) * cur_h;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= due + 3; k++) begin
      if (inject && k == 10) begin req_valid = 1'b1; req_op = 2'd1; req_addr = 8'd12; req_wdata = 16'hDEAD; end
      if (inject && k == 11) req_valid = 1'b0;
      @(negedge clk);
      if (ack !== (k == due)) bad++;
      if (k == due) got = rd_data;
    end
    chk(bad == 0, {tag, " R2 ack cycle"}, bad, 0);
    chk(got == exp, {tag, " R2 read data"}, got, exp);
  endtask

  task automatic do_mod(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                        input int limit, output bit seen, output int at);
    seen = 1'b0; at = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < limit && !seen; k++) begin
      @(negedge clk);
      if (ack) begin seen = 1'b1; at = cyc; end
    end
  endtask

  task automatic run_all();
    bit seen;
    int at, e0, bad;
    half_div = 8'd3; cur_h = 3;
    do_reset(6);
    do_read(8'd5, 6, 0, "narrow addr 5");
    do_read(8'd63, 6, 0, "narrow addr 63");

    bad = 0;
    @(negedge clk); req_valid = 1'b1; req_op = 2'd3; req_addr = 8'd4;
    @(negedge clk); req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (busy || ack || ee_cs) bad++; end
    chk(bad == 0, "R10 opcode 3 not accepted", bad, 0);

    do_read(8'd7, 6, 1, "read with request while busy");
    bad = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (ack || busy) bad++; end
    chk(bad == 0, "R10 no action after ignored request", bad, 0);
    chk(mem[12] == init_word(12, 6), "R10 memory untouched", mem[12], init_word(12, 6));

    half_div = 8'd1; cur_h = 2; do_read(8'd20, 6, 0, "R4 half_div=1");
    half_div = 8'd0; cur_h = 2; do_read(8'd33, 6, 0, "R4 half_div=0");
    half_div = 8'd5; cur_h = 5; do_read(8'd40, 6, 0, "R4 half_div=5");

    half_div = 8'd2; cur_h = 2;
    e0 = ewen_cnt;
    do_mod(2'd1, 8'd9, 16'hBEEF, 3000, seen, at);
    chk(seen, "R5 write acknowledged", seen, 1);
    chk(ewen_cnt == e0 + 1, "R5 write-enable frame sent", ewen_cnt, e0 + 1);
    chk(mem[9] == 16'hBEEF, "R5 word written", mem[9], 16'hBEEF);
    chk(at > ready_at && at <= ready_at + 2 * cur_h + 3, "R7 ack after ready", at, ready_at);
    do_read(8'd9, 6, 0, "R5 readback");

    e0 = ewen_cnt;
    do_mod(2'd2, 8'd44, 16'h0, 3000, seen, at);
    chk(seen && ewen_cnt == e0 + 1, "R6 erase with enable", ewen_cnt, e0 + 1);
    chk(mem[44] == 16'hFFFF, "R6 word erased", mem[44], 16'hFFFF);
    chk(at > ready_at && at <= ready_at + 2 * cur_h + 3, "R7 erase ack after ready", at, ready_at);
    do_read(8'd44, 6, 0, "R6 readback");
    chk(noprot_cnt == 0, "R5 no unprotected write frames", noprot_cnt, 0);

    stuck = 1'b1;
    chk(err_timeout == 1'b0, "R8 no error before timeout", err_timeout, 0);
    do_mod(2'd1, 8'd3, 16'h1234, 30000, seen, at);
    chk(seen, "R8 ack despite timeout", seen, 1);
    chk(err_timeout == 1'b1, "R8 timeout flag set", err_timeout, 1);
    stuck = 1'b0;
    repeat (60) @(negedge clk);
    do_read(8'd3, 6, 0, "R8 access after timeout");
    chk(err_timeout == 1'b1, "R8 flag sticky", err_timeout, 1);

    chk(viol_di == 0, "R3 data stable with clock high", viol_di, 0);
    chk(viol_ph == 0, "R4 phase length", viol_ph, 0);
    chk(viol_end == 0, "R9 frame ending", viol_end, 0);

    half_div = 8'd3; cur_h = 3;
    do_reset(8);
    chk(err_timeout == 1'b0, "R11 error cleared by reset", err_timeout, 0);
    do_read(8'd200, 8, 0, "wide addr 200");
    do_mod(2'd1, 8'hF3, 16'h0C0A, 4000, seen, at);
    chk(seen && mem[8'hF3] == 16'h0C0A, "R5 wide write", mem[8'hF3], 16'h0C0A);
    do_read(8'hF3, 8, 0, "R5 wide readback");
    chk(viol_di == 0 && viol_ph == 0 && viol_end == 0, "R9 wide frame timing",
        viol_di + viol_ph + viol_end, 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin repeat (190000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule